// File: doc/BRIEF.md
# SCSI DMA Channel Controller

This block is the register file and control engine of one bus-master DMA channel in a SCSI host adapter. Software programs a start byte count, a start memory address and a start descriptor address through eight word-indexed 32-bit registers, then writes a command. The start command loads the working counters from the start registers and arms the channel. A transfer requester (the SCSI core's data path) then asks for chunks by presenting a length and a direction. In the same cycle the block answers with the granted length and the current memory address, and at the next clock edge it advances its working count and working address.

The block merges the SCSI core's interrupt line with its own completion flag into one level-sensitive interrupt output. A strap-like control input picks how software acknowledges status. In write-one-to-clear mode, a status write drops the error, abort and done bits written as 1. In read-to-clear mode, status writes are ignored, and a status read returns the current value and then drops those three bits.

The channel state machine has two states. CH_OFF is the reset state and means the channel is disabled. CH_RUN means the channel is enabled. The transition "go" (CH_OFF to CH_RUN) is taken on a start command. The transition "halt" (CH_RUN to CH_OFF) is taken on an idle command. Every other command leaves the state where it is.

Top module: `scsi_dma_chan`

## Requirements
- R1: After reset, every register reads 0 except the working address, which reads 0xFFFFFFFF, and the working descriptor address, which reads 0xFFFFFFFD. The channel is disabled and the interrupt output is low.
- R2: The command register's bits [1:0] select the operation: 0 idle, 1 blast, 2 abort, 3 start. On a start command, start count (index 1) is copied into working count (index 3), start address (index 2) into working address (index 4), and start descriptor address (index 6) into working descriptor address (index 7). The channel is then enabled. The command word reads back from index 0 as written.
- R3: A start command clears status bits [5:0] (bit 0 power-down, 1 error, 2 abort, 3 done, 4 SCSI core interrupt, 5 blast complete).
- R4: An idle command disables the channel. A blast command sets status bit 5 and changes nothing else. An abort command raises the cancel output for exactly the one cycle after the write.
- R5: Writes to indexes 3, 4 and 7 are ignored.
- R6: A chunk request whose direction (1 = device to memory) differs from command bit 7 is ignored. The granted length is 0, the acknowledge output is low, and the counters do not change.
- R7: A matching request is granted the smaller of its length and the working count, at the current working address. At the next edge, working count falls by the granted length and working address rises by it.
- R8: A rising edge on the core interrupt input sets status bit 4. If, at that edge, the command is start and the working count is zero, status bit 3 is set in the same cycle. While the core interrupt input is low, bit 4 is cleared.
- R9: With the clear-mode input at 1, a write to status (index 5) clears each of bits 1, 2 and 3 whose written bit is 1. Other bits are unaffected.
- R10: With the clear-mode input at 0, writes to status are ignored. A status read returns the current value, and bits 1 to 3 are clear from the next cycle.
- R11: The interrupt output is status bit 4 OR (command bit 6 AND status bit 3).
- R12: When a register write and a core interrupt edge fall in the same cycle, the write is applied first, and the done decision uses the command and working count that result from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (only reads of status have side effects) |
| reg_idx | input | 3 | Word index of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the indexed register (combinational) |
| clr_on_write | input | 1 | 1: write-one-to-clear status; 0: read-to-clear status |
| core_irq | input | 1 | Interrupt level from the SCSI core |
| irq_out | output | 1 | Combined level-sensitive interrupt |
| chan_en | output | 1 | Channel enabled (state CH_RUN) |
| cancel | output | 1 | One-cycle cancel pulse toward the SCSI core |
| xfer_req | input | 1 | Chunk request valid |
| xfer_dir | input | 1 | Chunk direction, 1 = device to memory |
| xfer_len | input | DATA_W | Requested chunk length in bytes |
| xfer_ack | output | 1 | Request accepted (direction matches) |
| xfer_glen | output | DATA_W | Granted length |
| xfer_addr | output | DATA_W | Memory address of the chunk |

## Verification
The hardest case to reach is a rising core interrupt that lands in the same cycle as a start-command write with a zero start count. Here the done flag depends on the command and count values that exist only after the write. The bench first parks the core interrupt low, then drives the start write and the interrupt edge from one falling-edge slot. The expected status has done and core-interrupt set and blast-complete cleared. The read-to-clear and interrupt-enable gating cases are also delicate, because any stray status read erases the evidence. The bench therefore observes the interrupt output before it reads status.

// File: rtl/scsi_dma_pkg.sv
package scsi_dma_pkg;
    localparam int IDX_W   = 3;
    localparam int STAT_W  = 6;

    localparam logic [IDX_W-1:0] IX_CMD   = 3'd0;
    localparam logic [IDX_W-1:0] IX_SCNT  = 3'd1;
    localparam logic [IDX_W-1:0] IX_SADR  = 3'd2;
    localparam logic [IDX_W-1:0] IX_WCNT  = 3'd3;
    localparam logic [IDX_W-1:0] IX_WADR  = 3'd4;
    localparam logic [IDX_W-1:0] IX_STAT  = 3'd5;
    localparam logic [IDX_W-1:0] IX_SDESC = 3'd6;
    localparam logic [IDX_W-1:0] IX_WDESC = 3'd7;

    localparam int CB_DONE_IE = 6;
    localparam int CB_DIR     = 7;

    localparam int SB_ERR   = 1;
    localparam int SB_DONE  = 3;
    localparam int SB_CORE  = 4;
    localparam int SB_BLAST = 5;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_BLAST = 2'd1,
        OP_ABORT = 2'd2,
        OP_START = 2'd3
    } dma_op_e;

    typedef enum logic {
        CH_OFF = 1'b0,
        CH_RUN = 1'b1
    } chan_state_e;
endpackage

// File: rtl/scsi_dma_fsm.sv
module scsi_dma_fsm
    import scsi_dma_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cmd_wr,
    input  dma_op_e cmd_op,
    output logic    chan_en,
    output logic    cancel
);
    chan_state_e state_q, state_d;
    logic        cancel_q;

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF: if (cmd_wr && cmd_op == OP_START) state_d = CH_RUN;  // go
            CH_RUN: if (cmd_wr && cmd_op == OP_IDLE)  state_d = CH_OFF;  // halt
            default: state_d = CH_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) cancel_q <= 1'b0;
        else        cancel_q <= cmd_wr && (cmd_op == OP_ABORT);
    end

    assign chan_en = (state_q == CH_RUN);
    assign cancel  = cancel_q;
endmodule

// File: rtl/scsi_dma_grant.sv
module scsi_dma_grant #(
    parameter int DATA_W = 32
) (
    input  logic              req,
    input  logic              dir,
    input  logic [DATA_W-1:0] len,
    input  logic              cmd_dir,
    input  logic [DATA_W-1:0] wcnt,
    output logic              ok,
    output logic [DATA_W-1:0] glen
);
    always_comb begin
        ok   = req && (dir == cmd_dir);
        glen = '0;
        if (ok) glen = (len < wcnt) ? len : wcnt;
    end
endmodule

// File: rtl/scsi_dma_status.sv
module scsi_dma_status
    import scsi_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr,
    input  logic              blast_wr,
    input  logic [2:0]        wclr_mask,
    input  logic              rd_clr,
    input  logic              core_irq,
    input  logic              done_arm,
    input  logic              done_ie,
    output logic [STAT_W-1:0] stat,
    output logic              irq_out
);
    logic [STAT_W-1:0] stat_q, stat_d;
    logic              core_q;
    logic              core_rise;

    assign core_rise = core_irq && !core_q;

    // register-side effects first, core interrupt afterwards
    always_comb begin
        stat_d = stat_q;
        if (start_wr) stat_d = '0;
        if (blast_wr) stat_d[SB_BLAST] = 1'b1;
        stat_d[SB_DONE:SB_ERR] = stat_d[SB_DONE:SB_ERR] & ~wclr_mask;
        if (rd_clr)   stat_d[SB_DONE:SB_ERR] = '0;
        if (core_rise) begin
            stat_d[SB_CORE] = 1'b1;
            if (done_arm) stat_d[SB_DONE] = 1'b1;
        end else if (!core_irq) begin
            stat_d[SB_CORE] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            core_q <= 1'b0;
        end else begin
            stat_q <= stat_d;
            core_q <= core_irq;
        end
    end

    assign stat    = stat_q;
    assign irq_out = stat_q[SB_CORE] | (done_ie & stat_q[SB_DONE]);
endmodule

// File: rtl/scsi_dma_chan.sv
module scsi_dma_chan
    import scsi_dma_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_idx,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              clr_on_write,
    input  logic              core_irq,
    output logic              irq_out,
    output logic              chan_en,
    output logic              cancel,
    input  logic              xfer_req,
    input  logic              xfer_dir,
    input  logic [DATA_W-1:0] xfer_len,
    output logic              xfer_ack,
    output logic [DATA_W-1:0] xfer_glen,
    output logic [DATA_W-1:0] xfer_addr
);
    localparam logic [DATA_W-1:0] WADR_RST  = '1;
    localparam logic [DATA_W-1:0] WDESC_RST = {{(DATA_W-2){1'b1}}, 2'b01};

    logic [DATA_W-1:0] cmd_q, scnt_q, sadr_q, wcnt_q, wadr_q, sdesc_q, wdesc_q;
    logic [DATA_W-1:0] cmd_nx, wcnt_nx;
    logic [STAT_W-1:0] stat;
    logic              cmd_wr, start_wr, blast_wr, rd_clr;
    logic [2:0]        wclr_mask;
    dma_op_e           wr_op;

    assign wr_op    = dma_op_e'(reg_wdata[1:0]);
    assign cmd_wr   = reg_wr && (reg_idx == IX_CMD);
    assign start_wr = cmd_wr && (wr_op == OP_START);
    assign blast_wr = cmd_wr && (wr_op == OP_BLAST);
    assign rd_clr   = reg_rd && (reg_idx == IX_STAT) && !clr_on_write;
    assign wclr_mask = (reg_wr && reg_idx == IX_STAT && clr_on_write)
                       ? reg_wdata[SB_DONE:SB_ERR] : 3'b000;

    scsi_dma_grant #(.DATA_W(DATA_W)) u_grant (
        .req(xfer_req), .dir(xfer_dir), .len(xfer_len),
        .cmd_dir(cmd_q[CB_DIR]), .wcnt(wcnt_q),
        .ok(xfer_ack), .glen(xfer_glen)
    );
    assign xfer_addr = wadr_q;

    assign cmd_nx  = cmd_wr ? reg_wdata : cmd_q;
    assign wcnt_nx = start_wr ? scnt_q : (xfer_ack ? wcnt_q - xfer_glen : wcnt_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            scnt_q  <= '0;
            sadr_q  <= '0;
            sdesc_q <= '0;
            wcnt_q  <= '0;
            wadr_q  <= WADR_RST;
            wdesc_q <= WDESC_RST;
        end else begin
            cmd_q  <= cmd_nx;
            wcnt_q <= wcnt_nx;
            if (reg_wr && reg_idx == IX_SCNT)  scnt_q  <= reg_wdata;
            if (reg_wr && reg_idx == IX_SADR)  sadr_q  <= reg_wdata;
            if (reg_wr && reg_idx == IX_SDESC) sdesc_q <= reg_wdata;
            if (start_wr) begin
                wadr_q  <= sadr_q;
                wdesc_q <= sdesc_q;
            end else if (xfer_ack) begin
                wadr_q  <= wadr_q + xfer_glen;
            end
        end
    end

    scsi_dma_status u_status (
        .clk(clk), .rst_n(rst_n),
        .start_wr(start_wr), .blast_wr(blast_wr),
        .wclr_mask(wclr_mask), .rd_clr(rd_clr),
        .core_irq(core_irq),
        .done_arm((dma_op_e'(cmd_nx[1:0]) == OP_START) && (wcnt_nx == '0)),
        .done_ie(cmd_q[CB_DONE_IE]),
        .stat(stat), .irq_out(irq_out)
    );

    scsi_dma_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr(cmd_wr), .cmd_op(wr_op),
        .chan_en(chan_en), .cancel(cancel)
    );

    always_comb begin
        unique case (reg_idx)
            IX_CMD:   reg_rdata = cmd_q;
            IX_SCNT:  reg_rdata = scnt_q;
            IX_SADR:  reg_rdata = sadr_q;
            IX_WCNT:  reg_rdata = wcnt_q;
            IX_WADR:  reg_rdata = wadr_q;
            IX_STAT:  reg_rdata = {{(DATA_W-STAT_W){1'b0}}, stat};
            IX_SDESC: reg_rdata = sdesc_q;
            default:  reg_rdata = wdesc_q;
        endcase
    end
endmodule

module scsi_dma_chan_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [2:0]        reg_idx,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              clr_on_write,
    input logic              core_irq,
    input logic              irq_out,
    input logic              chan_en,
    input logic              cancel,
    input logic              xfer_req,
    input logic              xfer_dir,
    input logic              xfer_ack,
    input logic [DATA_W-1:0] xfer_glen,
    input logic [DATA_W-1:0] wcnt,
    input logic [DATA_W-1:0] scnt,
    input logic [DATA_W-1:0] cmd,
    input logic [5:0]        stat
);
    // R4
    cancel_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |-> $past(reg_wr && reg_idx == 3'd0 && reg_wdata[1:0] == 2'd2));

    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_idx == 3'd0 && reg_wdata[1:0] == 2'd3)
        |=> (chan_en && wcnt == $past(scnt)));

    // R6
    dir_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && xfer_dir != cmd[7]) |-> (!xfer_ack && xfer_glen == '0));

    // R7
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ack && !(reg_wr && reg_idx == 3'd0 && reg_wdata[1:0] == 2'd3))
        |=> (wcnt == $past(wcnt) - $past(xfer_glen)));

    // R8
    core_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_irq) |=> (irq_out && stat[4]));

    // R10
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_idx == 3'd5 && !clr_on_write && !core_irq && !reg_wr)
        |=> (stat[3:1] == 3'b000));
endmodule

bind scsi_dma_chan scsi_dma_chan_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .clr_on_write(clr_on_write),
    .core_irq(core_irq), .irq_out(irq_out), .chan_en(chan_en),
    .cancel(cancel), .xfer_req(xfer_req), .xfer_dir(xfer_dir),
    .xfer_ack(xfer_ack), .xfer_glen(xfer_glen), .wcnt(wcnt_q),
    .scnt(scnt_q), .cmd(cmd_q), .stat(stat)
);

// File: tb/scsi_dma_chan_tb.sv
module scsi_dma_chan_tb;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]    reg_idx = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          clr_on_write = 1'b1;
    logic          core_irq = 1'b0;
    logic          irq_out, chan_en, cancel;
    logic          xfer_req = 1'b0, xfer_dir = 1'b0;
    logic [DW-1:0] xfer_len = '0;
    logic          xfer_ack;
    logic [DW-1:0] xfer_glen, xfer_addr;

    always #2.5 clk = ~clk;

    scsi_dma_chan #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .clr_on_write(clr_on_write), .core_irq(core_irq), .irq_out(irq_out),
        .chan_en(chan_en), .cancel(cancel), .xfer_req(xfer_req),
        .xfer_dir(xfer_dir), .xfer_len(xfer_len), .xfer_ack(xfer_ack),
        .xfer_glen(xfer_glen), .xfer_addr(xfer_addr)
    );

    // kinds: 0 rdata, 1 irq, 2 granted length, 3 address, 4 chan_en, 5 cancel
    typedef struct {
        int            kind;
        logic [DW-1:0] exp;
        string         tag;
    } item_t;

    item_t exp_q[$];
    event  item_ev;
    int    n_chk = 0, n_bad = 0;
    bit    done = 1'b0;

    // monitor: pops expected items and compares to the ports
    initial begin
        forever begin
            @(item_ev);
            while (exp_q.size() > 0) begin
                item_t it;
                logic [DW-1:0] act;
                it = exp_q.pop_front();
                case (it.kind)
                    0: act = reg_rdata;
                    1: act = {{(DW-1){1'b0}}, irq_out};
                    2: act = xfer_glen;
                    3: act = xfer_addr;
                    4: act = {{(DW-1){1'b0}}, chan_en};
                    default: act = {{(DW-1){1'b0}}, cancel};
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic push(input int kind, input logic [DW-1:0] e, input string tag);
        item_t it;
        it.kind = kind; it.exp = e; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic wr(input logic [2:0] idx, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, input logic [DW-1:0] e, input string tag);
        @(negedge clk);
        reg_rd = 1'b1; reg_idx = idx;
        #1; push(0, e, tag); -> item_ev;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic look(input int kind, input logic [DW-1:0] e, input string tag);
        @(negedge clk); #1;
        push(kind, e, tag); -> item_ev;
    endtask

    task automatic core(input logic v);
        @(negedge clk);
        core_irq = v;
    endtask

    task automatic xfer(input logic d, input logic [DW-1:0] len,
                        input logic [DW-1:0] elen, input logic [DW-1:0] eadr, input string tag);
        @(negedge clk);
        xfer_req = 1'b1; xfer_dir = d; xfer_len = len;
        #1; push(2, elen, tag); push(3, eadr, tag); -> item_ev;
        @(posedge clk); #1;
        xfer_req = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(3'd3, 32'h0, "R1 wcnt");
        rd(3'd4, 32'hFFFF_FFFF, "R1 wadr");
        rd(3'd7, 32'hFFFF_FFFD, "R1 wdesc");
        rd(3'd5, 32'h0, "R1 stat");
        rd(3'd0, 32'h0, "R1 cmd");
        look(1, 0, "R1 irq");
        look(4, 0, "R1 chan_en");

        wr(3'd1, 32'h100);
        wr(3'd2, 32'h1000);
        wr(3'd6, 32'h2000);
        // R5 ignored writes
        wr(3'd3, 32'h55); wr(3'd4, 32'h66); wr(3'd7, 32'h77);
        rd(3'd3, 32'h0, "R5 wcnt");
        rd(3'd4, 32'hFFFF_FFFF, "R5 wadr");
        rd(3'd7, 32'hFFFF_FFFD, "R5 wdesc");

        // R2 start, done irq enabled, memory to device
        wr(3'd0, 32'h43);
        rd(3'd3, 32'h100, "R2 wcnt");
        rd(3'd4, 32'h1000, "R2 wadr");
        rd(3'd7, 32'h2000, "R2 wdesc");
        rd(3'd0, 32'h43, "R2 cmd");
        look(4, 1, "R2 chan_en");

        // R6 wrong direction
        xfer(1'b1, 32'h10, 32'h0, 32'h1000, "R6 ignored");
        rd(3'd3, 32'h100, "R6 wcnt kept");
        // R7 chunks
        xfer(1'b0, 32'h40, 32'h40, 32'h1000, "R7 chunk1");
        rd(3'd3, 32'hC0, "R7 wcnt");
        rd(3'd4, 32'h1040, "R7 wadr");
        xfer(1'b0, 32'h200, 32'hC0, 32'h1040, "R7 clipped");
        rd(3'd3, 32'h0, "R7 wcnt zero");
        rd(3'd4, 32'h1100, "R7 wadr end");

        // R8 core irq with start active and zero count
        core(1'b1);
        look(1, 1, "R8 irq");
        rd(3'd5, 32'h18, "R8 stat core+done");
        // R9 write-one-to-clear
        wr(3'd5, 32'h08);
        rd(3'd5, 32'h10, "R9 done cleared");
        look(1, 1, "R11 irq from core bit");
        core(1'b0);
        rd(3'd5, 32'h00, "R8 core bit cleared");
        look(1, 0, "R11 irq low");

        // R10 read-to-clear
        core(1'b1);
        look(1, 1, "R8 irq again");
        clr_on_write = 1'b0;
        wr(3'd5, 32'h08);
        rd(3'd5, 32'h18, "R10 write ignored");
        rd(3'd5, 32'h10, "R10 read cleared");
        core(1'b0);

        // R11 done gating by enable bit
        wr(3'd1, 32'h0);
        wr(3'd0, 32'h03);
        core(1'b1);
        look(1, 1, "R11 core");
        core(1'b0);
        look(1, 0, "R11 done masked");
        wr(3'd0, 32'h40);
        look(1, 1, "R11 done enabled");
        look(4, 0, "R4 idle halts");
        rd(3'd5, 32'h08, "R10 done seen");
        look(1, 0, "R10 irq after read clear");

        // R4 blast and abort
        wr(3'd0, 32'h01);
        rd(3'd5, 32'h20, "R4 blast bit");
        wr(3'd0, 32'h02);
        look(5, 1, "R4 cancel pulse");
        look(5, 0, "R4 cancel one cycle");

        // R12 write and core edge in one cycle; R3 start clears blast bit
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = 3'd0; reg_wdata = 32'h43; core_irq = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
        rd(3'd5, 32'h18, "R12 done from same-cycle start");
        look(4, 1, "R2 go again");
        core(1'b0);

        // R7 device-to-memory direction
        wr(3'd1, 32'h20);
        wr(3'd2, 32'h3000);
        wr(3'd0, 32'hC3);
        rd(3'd5, 32'h0, "R3 status cleared");
        xfer(1'b1, 32'h8, 32'h8, 32'h3000, "R7 dir1 chunk");
        rd(3'd3, 32'h18, "R7 dir1 wcnt");
        xfer(1'b0, 32'h4, 32'h0, 32'h3008, "R6 dir0 ignored");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule